// File: doc/BRIEF.md
# Dual-Core Mailbox and Hardware Lock Bank

This block sits between two processor cores and gives them a way to pass words to each other and to guard shared data. There are two one-way queues. Core 0 pushes into a queue that only core 1 can pop, and core 1 pushes into a queue that only core 0 can pop. Each core reaches the block through its own single-cycle register port. The port a request arrives on identifies the core, and a register returns that identity so the same code can find out which core it runs on.

The same block holds a bank of hardware locks. A read of a lock register is an atomic test-and-claim. A write to the same register releases the lock. A further register shows every held lock at once, and a write to it frees them all, so start-up code can clear locks left over from an earlier run. Read data is registered: it appears on a core's read-data lane in the cycle after the request.

Top module: `core_mailbox`

## Requirements
- R1: A read of word offset 0 returns 0 on the core 0 port and 1 on the core 1 port.
- R2: A word written by a core to offset 2 is returned by reads of offset 3 on the other core, in the order written. The two queues are independent.
- R3: A read of offset 1 (status) returns bit 0 = the incoming queue holds data and bit 1 = the outgoing queue has room. Each queue holds 8 words.
- R4: A write to offset 2 while the outgoing queue is full is dropped and sets the writer's sticky overflow flag (status bit 2).
- R5: A read of offset 3 while the incoming queue is empty returns 0 and sets the reader's sticky underflow flag (status bit 3). Reading until status bit 0 clears drains every stale word.
- R6: A write of any value to offset 1 clears only that core's overflow and underflow flags.
- R7: A read of word offset 32+n (n = 0..31) returns 1 and claims lock n if it was free, and returns 0 if it was already held.
- R8: A write of any value to offset 32+n by either core releases lock n. A claim and a release of the same lock in the same cycle leave the lock held.
- R9: When both cores read the same free lock in the same cycle, core 0 receives 1 and core 1 receives 0.
- R10: A read of offset 4 returns a bitmap of held locks (bit n = lock n). A write of any value to offset 4 releases every lock.
- R11: After reset both queues are empty, all locks are free, all flags are clear, each core's status reads 2, and the read-data lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Request valid, bit c for core c |
| bus_wr | input | 2 | 1 = write, 0 = read, bit c for core c |
| bus_addr | input | 12 | Word offset, 6 bits per core, core c at [6c+5:6c] |
| bus_wdata | input | 64 | Write data, 32 bits per core |
| bus_rdata | output | 64 | Registered read data, 32 bits per core |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-deep queues and 32 locks. This depth lets directed sequences fill a queue past its limit and drain it past empty in a few dozen cycles. The random phase picks lock indices from a small subset of the 32 locks, so claims often hit locks already held, and it mixes pushes and pops so both queues often reach their full and empty states. Simultaneous requests on both ports cover lock contention and cross-core release.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NCORE = 2;

    // word offsets in the low region; the lock region has the top address bit set
    localparam int OFS_ID    = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_TX    = 2;
    localparam int OFS_RX    = 3;
    localparam int OFS_LOCKS = 4;

    // status bit positions
    localparam int ST_RX_VALID = 0;
    localparam int ST_TX_ROOM  = 1;
    localparam int ST_OVF      = 2;
    localparam int ST_UNF      = 3;
    localparam int ST_W        = 4;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic push_ok, pop_ok;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign head  = s_q.mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop_ok) begin
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    assert_fifo_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && empty && !pop) |=> (head == $past(wdata)));
endmodule

// File: rtl/mbx_locks.sv
module mbx_locks #(
    parameter int NUM_LOCKS = 32,
    parameter int LW        = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           claim,
    input  logic [2*LW-1:0]      claim_idx,
    input  logic [1:0]           rel,
    input  logic [2*LW-1:0]      rel_idx,
    input  logic                 clr_all,
    output logic [1:0]           grant,
    output logic [NUM_LOCKS-1:0] held
);
    typedef struct packed {
        logic [NUM_LOCKS-1:0] held;
    } lock_state_t;

    lock_state_t s_d, s_q;
    logic [LW-1:0] cidx [2];
    logic [LW-1:0] ridx [2];

    assign held = s_q.held;

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            cidx[c] = claim_idx[c*LW +: LW];
            ridx[c] = rel_idx[c*LW +: LW];
        end
        // core 0 has priority on a contested free lock
        grant[0] = claim[0] && !s_q.held[cidx[0]];
        grant[1] = claim[1] && !s_q.held[cidx[1]] &&
                   !(grant[0] && (cidx[0] == cidx[1]));

        s_d = s_q;
        if (clr_all) s_d.held = '0;
        for (int c = 0; c < 2; c++) begin
            if (rel[c]) s_d.held[ridx[c]] = 1'b0;
        end
        for (int c = 0; c < 2; c++) begin
            if (grant[c]) s_d.held[cidx[c]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (claim[0] && claim[1] && cidx[0] == cidx[1]) |-> !(grant[0] && grant[1]));

    assert_grant_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |=> s_q.held[$past(cidx[0])]);

    assert_claim_beats_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |=> s_q.held[$past(cidx[1])]);
endmodule

// File: rtl/core_mailbox.sv
module core_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int NUM_LOCKS  = 32,
    parameter int AW         = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            bus_sel,
    input  logic [1:0]            bus_wr,
    input  logic [2*AW-1:0]       bus_addr,
    input  logic [2*DATA_W-1:0]   bus_wdata,
    output logic [2*DATA_W-1:0]   bus_rdata
);
    localparam int LW = $clog2(NUM_LOCKS);

    typedef struct packed {
        logic [1:0][DATA_W-1:0] rdata;
        logic [1:0]             ovf;
        logic [1:0]             unf;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [AW-1:0]      addr   [2];
    logic [DATA_W-1:0]  wdata  [2];
    logic [1:0]         rd_req, wr_req, lock_hit;
    logic [1:0]         tx_push, rx_pop, stat_wr, lock_clr;
    logic [1:0]         fifo_full, fifo_empty;
    logic [DATA_W-1:0]  fifo_head [2];
    logic [ST_W-1:0]    stat   [2];
    logic [1:0]         grant;
    logic [NUM_LOCKS-1:0] held;
    logic [2*LW-1:0]    lock_idx;

    for (genvar g = 0; g < NCORE; g++) begin : g_dec
        assign addr[g]     = bus_addr[g*AW +: AW];
        assign wdata[g]    = bus_wdata[g*DATA_W +: DATA_W];
        assign rd_req[g]   = bus_sel[g] && !bus_wr[g];
        assign wr_req[g]   = bus_sel[g] && bus_wr[g];
        assign lock_hit[g] = addr[g][AW-1];
        assign tx_push[g]  = wr_req[g] && !lock_hit[g] && addr[g] == AW'(OFS_TX);
        assign rx_pop[g]   = rd_req[g] && !lock_hit[g] && addr[g] == AW'(OFS_RX);
        assign stat_wr[g]  = wr_req[g] && !lock_hit[g] && addr[g] == AW'(OFS_STAT);
        assign lock_clr[g] = wr_req[g] && !lock_hit[g] && addr[g] == AW'(OFS_LOCKS);
        assign lock_idx[g*LW +: LW] = addr[g][LW-1:0];
        assign bus_rdata[g*DATA_W +: DATA_W] = st_q.rdata[g];

        assign stat[g][ST_RX_VALID] = !fifo_empty[1-g];
        assign stat[g][ST_TX_ROOM]  = !fifo_full[g];
        assign stat[g][ST_OVF]      = st_q.ovf[g];
        assign stat[g][ST_UNF]      = st_q.unf[g];

        // queue g is written by core g and read by the other core
        mbx_fifo #(
            .W     (DATA_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (tx_push[g]),
            .wdata (wdata[g]),
            .pop   (rx_pop[1-g]),
            .head  (fifo_head[g]),
            .full  (fifo_full[g]),
            .empty (fifo_empty[g])
        );
    end

    mbx_locks #(
        .NUM_LOCKS (NUM_LOCKS),
        .LW        (LW)
    ) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (rd_req & lock_hit),
        .claim_idx (lock_idx),
        .rel       (wr_req & lock_hit),
        .rel_idx   (lock_idx),
        .clr_all   (|lock_clr),
        .grant     (grant),
        .held      (held)
    );

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCORE; c++) begin
            st_d.rdata[c] = '0;
            if (rd_req[c]) begin
                if (lock_hit[c]) begin
                    st_d.rdata[c] = DATA_W'(grant[c]);
                end else if (addr[c] == AW'(OFS_ID)) begin
                    st_d.rdata[c] = DATA_W'(c);
                end else if (addr[c] == AW'(OFS_STAT)) begin
                    st_d.rdata[c] = DATA_W'(stat[c]);
                end else if (addr[c] == AW'(OFS_RX)) begin
                    st_d.rdata[c] = fifo_empty[1-c] ? '0 : fifo_head[1-c];
                end else if (addr[c] == AW'(OFS_LOCKS)) begin
                    st_d.rdata[c] = DATA_W'(held);
                end
            end
            if (stat_wr[c]) begin
                st_d.ovf[c] = 1'b0;
                st_d.unf[c] = 1'b0;
            end
            if (tx_push[c] && fifo_full[c])     st_d.ovf[c] = 1'b1;
            if (rx_pop[c] && fifo_empty[1-c])   st_d.unf[c] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_chk
        assert_id_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[g] && !lock_hit[g] && addr[g] == AW'(OFS_ID))
            |=> (bus_rdata[g*DATA_W +: DATA_W] == DATA_W'(g)));

        assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.ovf[g]) |-> $past(tx_push[g] && fifo_full[g]));

        assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_pop[g] && fifo_empty[1-g])
            |=> (bus_rdata[g*DATA_W +: DATA_W] == '0 && st_q.unf[g]));

        assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            stat_wr[g] |=> (!st_q.ovf[g] && !st_q.unf[g]));
    end
endmodule

// File: tb/core_mailbox_bench.sv
`timescale 1ns/1ps
module core_mailbox_bench;
    localparam int AW = 6;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_sel = '0;
    logic [1:0]      bus_wr = '0;
    logic [2*AW-1:0] bus_addr = '0;
    logic [2*DW-1:0] bus_wdata = '0;
    logic [2*DW-1:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model
    logic [31:0] mq [2][8];
    int          mh [2];
    int          mc [2];
    bit          movf [2];
    bit          munf [2];
    logic [31:0] mlock;

    always #2.5 clk = ~clk;

    core_mailbox u_core_mailbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // both ports in one cycle; result sampled after the capturing edge
    task automatic acc2(input bit s0, input bit w0, input int a0, input logic [31:0] d0,
                        input bit s1, input bit w1, input int a1, input logic [31:0] d1,
                        output logic [31:0] r0, output logic [31:0] r1);
        bus_sel   = {s1, s0};
        bus_wr    = {w1, w0};
        bus_addr  = {AW'(a1), AW'(a0)};
        bus_wdata = {d1, d0};
        @(negedge clk);
        r0 = bus_rdata[31:0];
        r1 = bus_rdata[63:32];
        bus_sel = '0;
    endtask

    task automatic acc(input int c, input bit w, input int a, input logic [31:0] d,
                       output logic [31:0] r);
        logic [31:0] r0, r1;
        if (c == 0) acc2(1, w, a, d, 0, 0, 0, 0, r0, r1);
        else        acc2(0, 0, 0, 0, 1, w, a, d, r0, r1);
        r = (c == 0) ? r0 : r1;
    endtask

    function automatic logic [31:0] exp_stat(input int c);
        return {28'd0, munf[c], movf[c], (mc[c] < 8), (mc[1-c] > 0)};
    endfunction

    task automatic m_push(input int c, input logic [31:0] d);
        if (mc[c] < 8) begin
            mq[c][(mh[c] + mc[c]) % 8] = d;
            mc[c]++;
        end else movf[c] = 1;
    endtask

    function automatic logic [31:0] m_pop(input int c);
        int f = 1 - c;
        logic [31:0] v;
        if (mc[f] == 0) begin
            munf[c] = 1;
            return 32'd0;
        end
        v = mq[f][mh[f]];
        mh[f] = (mh[f] + 1) % 8;
        mc[f]--;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r0, r1;
        void'($urandom(32'd20210212));
        for (int c = 0; c < 2; c++) begin
            mh[c] = 0; mc[c] = 0; movf[c] = 0; munf[c] = 0;
        end
        mlock = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 rdata lanes", bus_rdata[31:0] | bus_rdata[63:32], 32'd0);
        acc2(1, 0, 1, 0, 1, 0, 1, 0, r0, r1);
        check("R11 status core0", r0, 32'd2);
        check("R11 status core1", r1, 32'd2);
        acc(0, 0, 4, 0, r);
        check("R11 locks free", r, 32'd0);

        // R1: identity
        acc2(1, 0, 0, 0, 1, 0, 0, 0, r0, r1);
        check("R1 id core0", r0, 32'd0);
        check("R1 id core1", r1, 32'd1);

        // R4: fill core0 queue, ninth write dropped
        for (int i = 0; i < 9; i++) begin
            acc(0, 1, 2, 32'hA000_0000 + i, r);
            m_push(0, 32'hA000_0000 + i);
        end
        acc(0, 0, 1, 0, r);
        check("R4 overflow status core0", r, 32'h4);
        acc(1, 0, 1, 0, r);
        check("R3 data waiting core1", r, 32'h3);

        // R2: drain in order; R5: extra read gives zero and underflow
        for (int i = 0; i < 8; i++) begin
            acc(1, 0, 3, 0, r);
            check("R2 order core0->core1", r, m_pop(1));
        end
        acc(1, 0, 3, 0, r);
        check("R5 empty read zero", r, m_pop(1));
        acc(1, 0, 1, 0, r);
        check("R5 underflow status core1", r, 32'hA);

        // R6: clearing core1 leaves core0 flag
        acc(1, 1, 1, 32'hFFFF_FFFF, r);
        munf[1] = 0;
        acc2(1, 0, 1, 0, 1, 0, 1, 0, r0, r1);
        check("R6 core1 cleared", r1, 32'h2);
        check("R6 core0 untouched", r0, 32'h6);
        acc(0, 1, 1, 0, r);
        movf[0] = 0;
        acc(0, 0, 1, 0, r);
        check("R6 core0 cleared", r, 32'h2);

        // R2: reverse direction, simultaneous push and pop
        acc(1, 1, 2, 32'h1234_5678, r);
        m_push(1, 32'h1234_5678);
        acc2(1, 0, 3, 0, 1, 1, 2, 32'h0BAD_F00D, r0, r1);
        check("R2 core1->core0", r0, m_pop(0));
        m_push(1, 32'h0BAD_F00D);
        acc(0, 0, 3, 0, r);
        check("R2 core1->core0 second", r, m_pop(0));

        // R9: contested claim
        acc2(1, 0, 32 + 5, 0, 1, 0, 32 + 5, 0, r0, r1);
        check("R9 core0 wins", r0, 32'd1);
        check("R9 core1 loses", r1, 32'd0);
        acc(1, 0, 32 + 5, 0, r);
        check("R7 held lock fails", r, 32'd0);
        acc(1, 0, 4, 0, r);
        check("R10 bitmap one lock", r, 32'h20);
        // R8: release by the other core, then claim succeeds
        acc(1, 1, 32 + 5, 32'd0, r);
        acc(1, 0, 32 + 5, 0, r);
        check("R8 released then claimed", r, 32'd1);
        // R8: claim and release same cycle leaves it held
        acc2(1, 0, 32 + 9, 0, 1, 1, 32 + 9, 0, r0, r1);
        check("R8 claim beats release", r0, 32'd1);
        acc(0, 0, 32 + 7, 0, r);
        acc(0, 0, 4, 0, r);
        check("R10 bitmap three locks", r, 32'h2A0);
        acc(1, 1, 4, 32'd0, r);
        acc(0, 0, 4, 0, r);
        check("R10 release all", r, 32'd0);

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int c = $urandom % 2;
            int k = $urandom % 6;
            int li = $urandom % 4;
            logic [31:0] d = $urandom;
            case (k)
                0, 1: begin
                    acc(c, 1, 2, d, r);
                    m_push(c, d);
                end
                2: begin
                    acc(c, 0, 3, 0, r);
                    check("R2 R5 random pop", r, m_pop(c));
                end
                3: begin
                    acc(c, 0, 1, 0, r);
                    check("R3 random status", r, exp_stat(c));
                    if (($urandom % 4) == 0) begin
                        acc(c, 1, 1, 0, r);
                        movf[c] = 0; munf[c] = 0;
                    end
                end
                4: begin
                    acc(c, 0, 32 + li, 0, r);
                    check("R7 random claim", r, {31'd0, !mlock[li]});
                    mlock[li] = 1'b1;
                end
                default: begin
                    acc(c, 1, 32 + li, d, r);
                    mlock[li] = 1'b0;
                end
            endcase
        end
        acc(0, 0, 4, 0, r);
        check("R10 random bitmap", r, mlock);

        done = 1;
        summary();
        $finish;
    end
endmodule